// File: doc/BRIEF.md
# Flag Offset Loader

This block produces the two threshold values that a FIFO's partial-fill flags compare against: the empty-side offset `ofs_x` and the full-side offset `ofs_y`. Both live in the write clock domain. The loading method is chosen while reset is held, from two pins that take on a second role once reset is released.

There are three methods. A preset method loads one of two fixed constants into both offsets. A parallel method takes both offsets from the write data bus on two enabled writes. A serial method shifts single bits into one combined chain that holds Y above X. `load_done` shows when the offsets are final. After that, the loader does not change them again until the next reset.

Top module: `flag_offset_loader`

## Requirements
- R1: The method is captured from `{fsel_en_n, fsel_dat}` only on clock edges while `rst_n` is low. Changes to these pins after reset never change the method.
- R2: The method encodings are 2'b11 for serial, 2'b00 for parallel, 2'b01 for preset A (default 8) and 2'b10 for preset B (default 64).
- R3: In a preset method, `ofs_x` and `ofs_y` both equal the chosen preset, and `load_done` is high from the first cycle after reset is released.
- R4: In serial mode, each rising clock edge with `fsel_en_n` low captures `fsel_dat`. Edges with `fsel_en_n` high capture nothing, whatever `fsel_dat` is.
- R5: A serial load takes 2*OFS_W bits (18 by default), sent most significant bit first. The first bit becomes the MSB of `ofs_y` and the last bit becomes the LSB of `ofs_x`.
- R6: In parallel mode, the first write with `wr_en` high loads `ofs_x` from `wr_data[OFS_W-1:0]`, and the second such write loads `ofs_y` from the same bits. Cycles with `wr_en` low leave both offsets unchanged. `wr_en` has no effect in the other methods.
- R7: `load_done` rises after the edge that takes the final serial bit or the second parallel write. It then stays high, and any further serial bits or writes leave both offsets unchanged.
- R8: After a reset in serial or parallel mode, `ofs_x`, `ofs_y` and `load_done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-domain clock |
| rst_n | input | 1 | Synchronous active-low reset; the method is captured while it is low |
| fsel_en_n | input | 1 | Method select bit 1 during reset; active-low serial enable afterwards |
| fsel_dat | input | 1 | Method select bit 0 during reset; serial data bit afterwards |
| wr_en | input | 1 | Write enable for parallel loading |
| wr_data | input | DATA_W | Write data bus; the low OFS_W bits are used |
| ofs_x | output | OFS_W | Empty-side offset |
| ofs_y | output | OFS_W | Full-side offset |
| load_done | output | 1 | High once the offsets are final |

## Verification
The assertions assume that reset is held for at least one clock edge, so a method has been captured before they are enabled. They also assume that `fsel_en_n`, `fsel_dat` and `wr_en` are stable around each rising edge. The bench meets both assumptions: it holds reset for three edges and changes every input only on the falling clock edge. The stimulus deliberately moves the dual-purpose pins and `wr_en` in methods where they must be ignored. It also inserts idle gaps between serial bits, so the capture rules are tested under the timing the assertions expect.

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
  parameter int OFS_W    = 9,
  parameter int DATA_W   = 36,
  parameter int PRESET_A = 8,
  parameter int PRESET_B = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsel_en_n,
  input  logic              fsel_dat,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFS_W-1:0]  ofs_x,
  output logic [OFS_W-1:0]  ofs_y,
  output logic              load_done
);
  localparam int TOT   = 2 * OFS_W;
  localparam int CNT_W = $clog2(TOT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOT - 1);
  localparam logic [OFS_W-1:0] PA = OFS_W'(PRESET_A);
  localparam logic [OFS_W-1:0] PB = OFS_W'(PRESET_B);

  typedef enum logic [1:0] {M_PAR = 2'b00, M_PRE_A = 2'b01, M_PRE_B = 2'b10, M_SER = 2'b11} mode_e;

  mode_e            mode_q;
  logic [TOT-1:0]   chain;
  logic [CNT_W-1:0] cnt;
  logic             done;

  wire   mode_e pin_mode  = mode_e'({fsel_en_n, fsel_dat});
  wire   ser_take         = (mode_q == M_SER) && !fsel_en_n && !done;
  wire   par_take         = (mode_q == M_PAR) && wr_en && !done;
  wire   unused_hi        = ^wr_data[DATA_W-1:OFS_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= pin_mode;
      cnt    <= '0;
      case (pin_mode)
        M_PRE_A: begin chain <= {PA, PA}; done <= 1'b1; end
        M_PRE_B: begin chain <= {PB, PB}; done <= 1'b1; end
        default: begin chain <= '0;       done <= 1'b0; end
      endcase
    end else if (ser_take) begin
      chain <= {chain[TOT-2:0], fsel_dat};
      cnt   <= cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end else if (par_take) begin
      cnt <= cnt + 1'b1;
      if (cnt == '0) chain[OFS_W-1:0] <= wr_data[OFS_W-1:0];
      else begin
        chain[TOT-1:OFS_W] <= wr_data[OFS_W-1:0];
        done <= 1'b1;
      end
    end
  end

  assign ofs_y     = chain[TOT-1:OFS_W];
  assign ofs_x     = chain[OFS_W-1:0];
  assign load_done = done;

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);

  // R7
  frozen_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> $stable(ofs_x) && $stable(ofs_y));

  // R3
  preset_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PRE_A || mode_q == M_PRE_B) |-> load_done);

  // R4
  serial_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SER && !load_done && !fsel_en_n) |=> ofs_x[0] == $past(fsel_dat));

  // R4
  serial_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SER && fsel_en_n) |=> $stable(ofs_x) && $stable(ofs_y) && $stable(load_done));

  // R6
  par_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PAR && !load_done && wr_en && cnt == '0) |=> ofs_x == $past(wr_data[OFS_W-1:0]) && !load_done);

  // R6
  par_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PAR && !wr_en) |=> $stable(ofs_x) && $stable(ofs_y));
endmodule

// File: tb/flag_offset_loader_tb.sv
`timescale 1ns/1ps
module flag_offset_loader_tb_top;
  localparam int OW = 9;
  localparam int DW = 36;
  localparam int NV = 4;
  localparam logic [2*OW-1:0] PAT [NV] = '{18'h3FFFF, 18'h20001, 18'h15A5C, 18'h0F0F3};
  localparam int GAP [NV] = '{0, 1, 3, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0, fen = 1'b1, fdat = 1'b1, wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [OW-1:0] ofs_x, ofs_y;
  logic load_done;
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flag_offset_loader dut_i (
    .clk(clk), .rst_n(rst_n), .fsel_en_n(fen), .fsel_dat(fdat),
    .wr_en(wr_en), .wr_data(wr_data),
    .ofs_x(ofs_x), .ofs_y(ofs_y), .load_done(load_done));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0; {fen, fdat} = m; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; fen = 1'b1; fdat = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int gap);
    fen = 1'b0; fdat = b;
    @(negedge clk);
    fen = 1'b1; fdat = ~b;
    repeat (gap) @(negedge clk);
  endtask

  task automatic par_write(input logic en, input logic [DW-1:0] d);
    wr_en = en; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      do_reset(2'b11);
      chk("R8 serial reset x", 32'(ofs_x), 0);
      chk("R8 serial reset done", 32'(load_done), 0);
      for (int i = 2*OW-1; i >= 0; i--) begin
        if (i == 0) chk("R7 done low before last bit", 32'(load_done), 0);
        send_bit(PAT[v][i], GAP[v]);
      end
      chk("R5 serial y", 32'(ofs_y), 32'(PAT[v][2*OW-1:OW]));
      chk("R5 serial x", 32'(ofs_x), 32'(PAT[v][OW-1:0]));
      chk("R7 serial done", 32'(load_done), 1);
    end

    send_bit(1'b0, 0); send_bit(1'b1, 1); send_bit(1'b0, 0);
    chk("R7 extra bits ignored x", 32'(ofs_x), 32'(PAT[NV-1][OW-1:0]));
    chk("R7 extra bits ignored y", 32'(ofs_y), 32'(PAT[NV-1][2*OW-1:OW]));

    do_reset(2'b11);
    par_write(1'b1, 36'h0_0000_01FF);
    chk("R6 wr_en no effect in serial", 32'(ofs_x), 0);
    fen = 1'b1; fdat = 1'b1; repeat (4) @(negedge clk);
    chk("R4 idle edges capture nothing", 32'(ofs_x), 0);

    do_reset(2'b00);
    chk("R8 parallel reset y", 32'(ofs_y), 0);
    chk("R8 parallel reset done", 32'(load_done), 0);
    par_write(1'b0, 36'h0_0000_0123);
    chk("R6 wr_en low ignored", 32'(ofs_x), 0);
    for (int k = 0; k < 3; k++) send_bit(1'b1, 0);
    chk("R1 serial pins ignored after reset", 32'(ofs_x), 0);
    par_write(1'b1, 36'hF_FFFF_F0A5);
    chk("R6 first write to x", 32'(ofs_x), 32'h0A5);
    chk("R7 done low after one write", 32'(load_done), 0);
    par_write(1'b1, 36'h0_0000_0F3C);
    chk("R6 second write to y", 32'(ofs_y), 32'h13C);
    chk("R6 x kept", 32'(ofs_x), 32'h0A5);
    chk("R7 parallel done", 32'(load_done), 1);
    par_write(1'b1, 36'h0_0000_0055);
    chk("R7 third write ignored", 32'(ofs_x), 32'h0A5);

    do_reset(2'b01);
    chk("R3 preset A x", 32'(ofs_x), 8);
    chk("R3 preset A y", 32'(ofs_y), 8);
    chk("R2 preset A done", 32'(load_done), 1);
    send_bit(1'b1, 0);
    par_write(1'b1, 36'h1FF);
    chk("R1 preset kept", 32'(ofs_x), 8);

    do_reset(2'b10);
    chk("R3 preset B x", 32'(ofs_x), 64);
    chk("R3 preset B y", 32'(ofs_y), 64);
    chk("R2 preset B done", 32'(load_done), 1);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule